// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block sits behind the serial shifter of an I2C target. It watches the bytes that follow a START or repeated START and decides whether this device is being addressed. The own address is programmable, either 7 bits wide or 10 bits wide. An answer to the general call can be switched on or off.

For every address byte, the recognizer gives one acknowledge decision. It also holds an addressed flag, a general-call flag and the transfer direction until the next START or STOP. Bytes in the data phase do not affect it. The shifter is expected to pulse `byte_vld_i` once per received byte, and `start_i` and `stop_i` once per bus condition.

The recognizer is a state machine with six states:

- `S_IDLE`: the bus is free or no START has been seen.
- `S_HDR`: the first address byte is expected.
- `S_LOW`: the second byte of a 10-bit address is expected.
- `S_RHDR`: a repeated START arrived after a 10-bit write match, and a header byte is expected.
- `S_ADDRD`: the device is addressed, and data bytes are passed over.
- `S_SKIP`: the device is not addressed, and it waits for the next START or STOP.

The transitions are as follows:

- STOP leads to `S_IDLE` from any state.
- START leads to `S_RHDR` from `S_ADDRD` when a 10-bit write match is armed. From anywhere else it leads to `S_HDR`.
- An address byte in `S_HDR` leads to `S_ADDRD` (7-bit hit or general call), to `S_LOW` (10-bit write header) or to `S_SKIP`.
- An address byte in `S_LOW` leads to `S_ADDRD` or `S_SKIP`.
- An address byte in `S_RHDR` leads to `S_ADDRD` (read header or general call), to `S_LOW` (write header) or to `S_SKIP`.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, `match_o`, `gcall_o`, `read_o`, `ack_vld_o` and `ack_o` are all 0.
- R2: In 7-bit mode, a first byte whose bits 7..1 equal `own_addr_i[6:0]` is acknowledged. The cycle after the byte, `match_o` is 1 and `read_o` equals bit 0 of the byte (1 means the target transmits).
- R3: In 7-bit mode, a first byte that does not match is not acknowledged and leaves `match_o` at 0. Later bytes of the same transfer produce no `ack_vld_o` pulse, even if their value would match.
- R4: A first byte of 0x00 is acknowledged with `gcall_o` = 1 and `match_o` = 0 only while `gc_en_i` is 1. Otherwise it is not acknowledged. The bytes 0x00 and 0x01 never count as an own-address match.
- R5: In 10-bit mode, a first byte of the form 11110 A9 A8 0 is acknowledged and leaves `match_o` at 0. Here A9 A8 equals `own_addr_i[9:8]`. A following byte equal to `own_addr_i[7:0]` is acknowledged and sets `match_o` = 1 with `read_o` = 0.
- R6: In 10-bit mode, a second byte that differs from `own_addr_i[7:0]` is not acknowledged, and `match_o` stays 0.
- R7: In 10-bit mode, a header byte 11110 A9 A8 1 that follows a START with no 10-bit write match armed is not acknowledged.
- R8: After a 10-bit write match, a repeated START followed by the matching header with R/W = 1 is acknowledged. It sets `match_o` = 1 and `read_o` = 1, and no second byte is expected. The same header with R/W = 0 starts a fresh two-byte sequence. Any other header is not acknowledged.
- R9: STOP clears `match_o`, `gcall_o` and `read_o` by the next cycle, and it disarms the pending 10-bit read sequence.
- R10: A START that does not continue a pending 10-bit read sequence clears `match_o`, `gcall_o` and `read_o` by the next cycle.
- R11: `ack_vld_o` pulses exactly one cycle after each address byte and never after a data byte. `ack_o` is 1 only while `ack_vld_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse: START or repeated START seen |
| stop_i | input | 1 | One-cycle pulse: STOP seen |
| byte_vld_i | input | 1 | One-cycle pulse: `byte_i` holds a received byte |
| byte_i | input | 8 | Received byte, bit 7 first on the wire |
| mode10_i | input | 1 | 1 selects a 10-bit own address, 0 selects 7-bit |
| own_addr_i | input | 10 | Own address (bits 6..0 used in 7-bit mode) |
| gc_en_i | input | 1 | 1 enables the general-call answer |
| match_o | output | 1 | Device addressed by its own address |
| gcall_o | output | 1 | Device addressed by the general call |
| read_o | output | 1 | Direction: 1 means the target transmits |
| ack_vld_o | output | 1 | Acknowledge decision ready for the last address byte |
| ack_o | output | 1 | 1 requests an ACK for that byte |

## Verification
On every cycle, the assertions check the following:

- The own-address and general-call flags are never both set.
- A read direction only appears with an own-address match.
- An acknowledge decision only follows a byte strobe.
- STOP and START leave the flags clear.
- A general call only rises while it is enabled.

Only the bench's scenarios can show that the decisions are right. Examples are the 10-bit header and low-byte pairing, the header-only read after a repeated START, and the disarming by STOP. They also show that data bytes are passed over without a response.

// File: rtl/i2c_adr_pkg.sv
package i2c_adr_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HDR,
        S_LOW,
        S_RHDR,
        S_ADDRD,
        S_SKIP
    } adr_state_e;

    typedef struct packed {
        logic gc;    // byte is the general-call value
        logic own7;  // bits 7..1 equal the 7-bit own address
        logic hdr;   // byte is the 10-bit header for the own address
        logic low;   // byte equals the low part of the 10-bit own address
        logic rw;    // direction bit of the byte
    } cmp_res_t;

endpackage

// File: rtl/adr_cmp.sv
module adr_cmp
    import i2c_adr_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int ADDR10_W = 10
) (
    input  logic [BYTE_W-1:0]   byte_i,
    input  logic [ADDR10_W-1:0] own_addr_i,
    output cmp_res_t            res_o
);
    localparam int ADDR7_W = BYTE_W - 1;
    localparam int HI_W    = ADDR10_W - BYTE_W;
    localparam int PFX_W   = BYTE_W - 1 - HI_W;
    localparam logic [PFX_W-1:0] HDR_PFX = {{(PFX_W-1){1'b1}}, 1'b0};

    logic [ADDR7_W-1:0] eq7;
    logic [BYTE_W-1:0]  eql;

    // bitwise equality, one cell per address bit
    for (genvar i = 0; i < ADDR7_W; i++) begin : g_eq7
        assign eq7[i] = (byte_i[i+1] == own_addr_i[i]);
    end
    for (genvar j = 0; j < BYTE_W; j++) begin : g_eql
        assign eql[j] = (byte_i[j] == own_addr_i[j]);
    end

    logic own7_zero;
    logic pfx_ok;
    logic hi_ok;

    always_comb begin
        own7_zero = (own_addr_i[ADDR7_W-1:0] == '0);
        pfx_ok    = (byte_i[BYTE_W-1:BYTE_W-PFX_W] == HDR_PFX);
        hi_ok     = (byte_i[HI_W:1] == own_addr_i[ADDR10_W-1:BYTE_W]);
        res_o.gc   = (byte_i == '0);
        res_o.own7 = (&eq7) && !own7_zero;
        res_o.hdr  = pfx_ok && hi_ok;
        res_o.low  = &eql;
        res_o.rw   = byte_i[0];
    end

endmodule

// File: rtl/adr_fsm.sv
module adr_fsm
    import i2c_adr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_i,
    input  logic     stop_i,
    input  logic     byte_vld_i,
    input  logic     mode10_i,
    input  logic     gc_en_i,
    input  cmp_res_t res_i,
    output logic     match_o,
    output logic     gcall_o,
    output logic     read_o,
    output logic     ack_vld_o,
    output logic     ack_o
);
    adr_state_e state_q, state_d;
    logic       armed_q, armed_d;
    logic       match_d, gcall_d, read_d, ack_vld_d, ack_d;

    always_comb begin
        state_d   = state_q;
        armed_d   = armed_q;
        match_d   = match_o;
        gcall_d   = gcall_o;
        read_d    = read_o;
        ack_vld_d = 1'b0;
        ack_d     = 1'b0;
        if (stop_i) begin
            state_d = S_IDLE;
            armed_d = 1'b0;
            match_d = 1'b0;
            gcall_d = 1'b0;
            read_d  = 1'b0;
        end else if (start_i) begin
            match_d = 1'b0;
            gcall_d = 1'b0;
            read_d  = 1'b0;
            if (state_q == S_ADDRD && armed_q) begin
                state_d = S_RHDR;
            end else begin
                state_d = S_HDR;
                armed_d = 1'b0;
            end
        end else if (byte_vld_i) begin
            unique case (state_q)
                S_HDR: begin
                    ack_vld_d = 1'b1;
                    if (res_i.gc && gc_en_i) begin
                        state_d = S_ADDRD;
                        gcall_d = 1'b1;
                        ack_d   = 1'b1;
                    end else if (!mode10_i && res_i.own7) begin
                        state_d = S_ADDRD;
                        match_d = 1'b1;
                        read_d  = res_i.rw;
                        ack_d   = 1'b1;
                    end else if (mode10_i && res_i.hdr && !res_i.rw) begin
                        state_d = S_LOW;
                        ack_d   = 1'b1;
                    end else begin
                        state_d = S_SKIP;
                    end
                end
                S_RHDR: begin
                    ack_vld_d = 1'b1;
                    if (res_i.gc && gc_en_i) begin
                        state_d = S_ADDRD;
                        gcall_d = 1'b1;
                        ack_d   = 1'b1;
                        armed_d = 1'b0;
                    end else if (mode10_i && res_i.hdr && res_i.rw) begin
                        state_d = S_ADDRD;
                        match_d = 1'b1;
                        read_d  = 1'b1;
                        ack_d   = 1'b1;
                    end else if (mode10_i && res_i.hdr) begin
                        state_d = S_LOW;
                        ack_d   = 1'b1;
                        armed_d = 1'b0;
                    end else begin
                        state_d = S_SKIP;
                        armed_d = 1'b0;
                    end
                end
                S_LOW: begin
                    ack_vld_d = 1'b1;
                    if (res_i.low) begin
                        state_d = S_ADDRD;
                        match_d = 1'b1;
                        read_d  = 1'b0;
                        ack_d   = 1'b1;
                        armed_d = 1'b1;
                    end else begin
                        state_d = S_SKIP;
                    end
                end
                S_IDLE, S_ADDRD, S_SKIP: begin
                    ack_vld_d = 1'b0;
                end
                default: begin
                    state_d = S_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            armed_q <= 1'b0;
        end else begin
            state_q <= state_d;
            armed_q <= armed_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_o   <= 1'b0;
            gcall_o   <= 1'b0;
            read_o    <= 1'b0;
            ack_vld_o <= 1'b0;
            ack_o     <= 1'b0;
        end else begin
            match_o   <= match_d;
            gcall_o   <= gcall_d;
            read_o    <= read_d;
            ack_vld_o <= ack_vld_d;
            ack_o     <= ack_d;
        end
    end

    // R4: own-address and general-call flags are exclusive
    p_flag_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({match_o, gcall_o}));

    // R2: a read direction only exists together with an own-address match
    p_read_needs_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        read_o |-> match_o);

    // R11: a decision only follows a byte strobe
    p_ack_after_byte_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld_o |-> $past(byte_vld_i));

    // R11: ack request only together with a decision
    p_ack_qualified_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> ack_vld_o);

    // R9: STOP leaves the flags clear
    p_stop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !match_o && !gcall_o && !read_o);

    // R10: START leaves the flags clear
    p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !stop_i) |=> !match_o && !gcall_o);

    // R4: general call only rises while enabled
    p_gc_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gcall_o) |-> $past(gc_en_i));

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_adr_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int ADDR10_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                stop_i,
    input  logic                byte_vld_i,
    input  logic [BYTE_W-1:0]   byte_i,
    input  logic                mode10_i,
    input  logic [ADDR10_W-1:0] own_addr_i,
    input  logic                gc_en_i,
    output logic                match_o,
    output logic                gcall_o,
    output logic                read_o,
    output logic                ack_vld_o,
    output logic                ack_o
);
    cmp_res_t cmp_res;

    adr_cmp #(
        .BYTE_W   (BYTE_W),
        .ADDR10_W (ADDR10_W)
    ) u_cmp (
        .byte_i     (byte_i),
        .own_addr_i (own_addr_i),
        .res_o      (cmp_res)
    );

    adr_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .stop_i     (stop_i),
        .byte_vld_i (byte_vld_i),
        .mode10_i   (mode10_i),
        .gc_en_i    (gc_en_i),
        .res_i      (cmp_res),
        .match_o    (match_o),
        .gcall_o    (gcall_o),
        .read_o     (read_o),
        .ack_vld_o  (ack_vld_o),
        .ack_o      (ack_o)
    );

endmodule

// File: tb/i2c_addr_match_bench.sv
module i2c_addr_match_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       stop_i = 1'b0;
    logic       byte_vld_i = 1'b0;
    logic [7:0] byte_i = '0;
    logic       mode10_i = 1'b0;
    logic [9:0] own_addr_i = '0;
    logic       gc_en_i = 1'b0;
    logic       match_o, gcall_o, read_o, ack_vld_o, ack_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        logic  ack;
        logic  match;
        logic  gc;
        logic  rd;
        string tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;  // 125 MHz

    i2c_addr_match u_i2c_addr_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .stop_i     (stop_i),
        .byte_vld_i (byte_vld_i),
        .byte_i     (byte_i),
        .mode10_i   (mode10_i),
        .own_addr_i (own_addr_i),
        .gc_en_i    (gc_en_i),
        .match_o    (match_o),
        .gcall_o    (gcall_o),
        .read_o     (read_o),
        .ack_vld_o  (ack_vld_o),
        .ack_o      (ack_o)
    );

    task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {ack,match,gc,rd} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // monitor: pops one expected decision per ack_vld_o pulse (R11)
    always @(negedge clk) begin
        if (rst_n && ack_vld_o) begin
            if (sb.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R11: unexpected decision actual=1 expected=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk({ack_o, match_o, gcall_o, read_o}, {e.ack, e.match, e.gc, e.rd}, e.tag);
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) stop_i = 1'b1;
        @(negedge clk) stop_i = 1'b0;
    endtask

    task automatic send_addr(input logic [7:0] b, input logic ack, input logic m,
                             input logic g, input logic r, input string tag);
        exp_t e;
        e.ack = ack; e.match = m; e.gc = g; e.rd = r; e.tag = tag;
        sb.push_back(e);
        @(negedge clk) begin byte_vld_i = 1'b1; byte_i = b; end
        @(negedge clk) byte_vld_i = 1'b0;
    endtask

    task automatic send_data(input logic [7:0] b);
        @(negedge clk) begin byte_vld_i = 1'b1; byte_i = b; end
        @(negedge clk) byte_vld_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic flags(input logic m, input logic g, input logic r, input string tag);
        chk({1'b0, match_o, gcall_o, read_o}, {1'b0, m, g, r}, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({ack_o, match_o, gcall_o, read_o}, 4'b0000, "R1");
        chk({3'b000, ack_vld_o}, 4'b0000, "R1");
        rst_n = 1'b1;

        // 7-bit mode, own address 0x2A
        own_addr_i = 10'h02A;
        pulse_start();
        send_addr(8'h54, 1, 1, 0, 0, "R2");
        send_data(8'h11);
        flags(1, 0, 0, "R2");
        pulse_stop();
        flags(0, 0, 0, "R9");
        pulse_start();
        send_addr(8'h55, 1, 1, 0, 1, "R2");
        send_data(8'hA0);
        pulse_stop();
        pulse_start();
        send_addr(8'h56, 0, 0, 0, 0, "R3");
        send_data(8'h54);  // would match, but is a data byte
        flags(0, 0, 0, "R3");
        pulse_stop();

        // general call
        gc_en_i = 1'b1;
        pulse_start();
        send_addr(8'h00, 1, 0, 1, 0, "R4");
        pulse_stop();
        flags(0, 0, 0, "R9");
        gc_en_i = 1'b0;
        pulse_start();
        send_addr(8'h00, 0, 0, 0, 0, "R4");
        pulse_stop();
        gc_en_i = 1'b1;
        pulse_start();
        send_addr(8'h01, 0, 0, 0, 0, "R4");
        pulse_stop();

        // repeated START in 7-bit mode clears the match
        pulse_start();
        send_addr(8'h55, 1, 1, 0, 1, "R10");
        pulse_start();
        flags(0, 0, 0, "R10");
        send_addr(8'h56, 0, 0, 0, 0, "R10");
        pulse_stop();

        // 10-bit mode, own address 0x2B5: header 0xF4/0xF5, low 0xB5
        mode10_i = 1'b1;
        own_addr_i = 10'h2B5;
        pulse_start();
        send_addr(8'hF4, 1, 0, 0, 0, "R5");
        send_addr(8'hB5, 1, 1, 0, 0, "R5");
        send_data(8'h33);
        pulse_start();
        flags(0, 0, 0, "R8");
        send_addr(8'hF5, 1, 1, 0, 1, "R8");
        send_data(8'hB5);
        flags(1, 0, 1, "R8");
        pulse_stop();

        pulse_start();
        send_addr(8'hF4, 1, 0, 0, 0, "R6");
        send_addr(8'hB4, 0, 0, 0, 0, "R6");
        pulse_stop();

        pulse_start();
        send_addr(8'hF5, 0, 0, 0, 0, "R7");
        pulse_stop();

        pulse_start();
        send_addr(8'hF4, 1, 0, 0, 0, "R9");
        send_addr(8'hB5, 1, 1, 0, 0, "R9");
        pulse_stop();
        pulse_start();
        send_addr(8'hF5, 0, 0, 0, 0, "R9");
        pulse_stop();

        pulse_start();
        send_addr(8'hF4, 1, 0, 0, 0, "R8");
        send_addr(8'hB5, 1, 1, 0, 0, "R8");
        pulse_start();
        send_addr(8'hF6, 0, 0, 0, 0, "R8");
        pulse_stop();

        pulse_start();
        send_addr(8'hF4, 1, 0, 0, 0, "R8");
        send_addr(8'hB5, 1, 1, 0, 0, "R8");
        pulse_start();
        send_addr(8'hF4, 1, 0, 0, 0, "R8");
        send_addr(8'hB5, 1, 1, 0, 0, "R8");
        pulse_stop();

        pulse_start();
        send_addr(8'h00, 1, 0, 1, 0, "R4");
        pulse_stop();
        pulse_start();
        send_addr(8'h6A, 0, 0, 0, 0, "R6");
        pulse_stop();

        repeat (3) @(negedge clk);
        chk({3'b000, sb.size() != 0}, 4'b0000, "R11");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule